// File: doc/BRIEF.md
# Extended-Range Cascaded Divider Sequencer

This block divides an input clock by counts far larger than a single programmable down counter can reach. An inner reloadable down counter produces one terminal pulse per sub-cycle. A small sub-cycle tally counts those pulses. Within each overall period, the inner counter is loaded with two kinds of value:

- on the first sub-cycle, the user's fine count;
- on each of the K sub-cycles after that, a fixed coarse count.

The overall period is therefore fine + K × coarse input clocks. For example, a fine count of 15690, a coarse count of 16000 and K = 2 give a period of 47690 clocks. The coarse count 16000 stands for a preset of 8000 in a divide-by-2 arrangement.

The single-cycle output pulse is typically fed back to a phase detector, or used as a long timeout tick. The three settings are sampled once per period, at the clock edge where the output pulse ends. The next period then runs on exactly those values. Changes made to the inputs during a period take effect only from the following period. A value below 3 is never loaded into the inner counter.

Top module: `extdiv_top`

## Requirements
- R1: While reset is asserted the output is low. After reset is released, the first output pulse appears after fine + K × coarse clock edges, using the values present at the first edge after release.
- R2: The number of input clocks between consecutive output pulses equals fine + K × coarse. Here fine, coarse and K are the values present at the edge that ends the earlier pulse.
- R3: The output is high for exactly one clock cycle per period.
- R4: The first sub-cycle of a period uses the fine count. Each of the following K sub-cycles uses the coarse count. The output fires at the end of sub-cycle K, counting from 0. The tally index never exceeds the sampled K.
- R5: Changes to fine, coarse or K made during a period do not alter that period's length. They apply from the next period.
- R6: A fine or coarse value below 3, including 0, is treated as 3.
- R7: With K = 0 the period equals the fine count alone.
- R8: The largest K (15) is supported, giving fine + 15 × coarse.
- R9: Between reloads, the inner counter decreases by exactly one per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| fine_cnt | input | N_W | Count loaded on the first sub-cycle of each period |
| coarse_cnt | input | N_W | Count loaded on each of the following sub-cycles |
| coarse_reps | input | K_W | Number K of coarse sub-cycles per period |
| div_pulse | output | 1 | One-clock pulse once per complete period |

## Verification
The first period after reset uses a fine count, coarse count and K that are all distinct from one another, so the measured length shows which count was loaded in which sub-cycle.

Directed settings cover the following cases:
- values below 3, which tell the clamp apart from a raw load;
- K = 0, which tells the terminal decode apart from a tally that always advances at least once;
- K = 15, which exercises the widest tally wrap.

Random settings are applied one clock after each pulse, in the middle of the following period. The bench expects that period's length to come from the earlier values, which separates sampling at the period boundary from sampling at every reload.

// File: rtl/extdiv_pkg.sv
package extdiv_pkg;
  localparam int MIN_LOAD = 3;
  typedef enum logic {SRC_FINE, SRC_COARSE} jam_src_e;
endpackage

// File: rtl/extdiv_core.sv
module extdiv_core
  import extdiv_pkg::*;
#(
  parameter int N_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N_W-1:0] jam_val,
  output logic           tc,
  output logic           idle,
  output logic           reload
);
  logic [N_W-1:0] cnt_q, cnt_d;
  logic           run_q, run_d;

  assign idle   = !run_q;
  assign tc     = run_q && (cnt_q == '0);
  assign reload = idle || tc;

  always_comb begin
    run_d = 1'b1;
    if (reload) cnt_d = jam_val - N_W'(1);
    else        cnt_d = cnt_q - N_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  // R6
  load_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt_q >= N_W'(MIN_LOAD - 1)));

  // R9
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - N_W'(1)));
endmodule

// File: rtl/extdiv_tally.sv
module extdiv_tally #(
  parameter int K_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           adv,
  input  logic [K_W-1:0] k_in,
  output logic           last
);
  logic [K_W-1:0] idx_q, idx_d;
  logic [K_W-1:0] k_q, k_d;

  assign last = (idx_q == k_q);

  always_comb begin
    idx_d = idx_q;
    k_d   = k_q;
    if (start) begin
      idx_d = '0;
      k_d   = k_in;
    end else if (adv) begin
      idx_d = idx_q + K_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      k_q   <= '0;
    end else begin
      idx_q <= idx_d;
      k_q   <= k_d;
    end
  end

  // R4
  tally_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= k_q);
endmodule

// File: rtl/extdiv_jamsel.sv
module extdiv_jamsel
  import extdiv_pkg::*;
#(
  parameter int N_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N_W-1:0] fine_in,
  input  logic [N_W-1:0] coarse_in,
  output logic [N_W-1:0] jam_val
);
  localparam logic [N_W-1:0] FLOOR = N_W'(MIN_LOAD);

  logic [N_W-1:0] coarse_q, coarse_d;
  logic [N_W-1:0] fine_c, coarse_c;
  jam_src_e       src;

  assign fine_c   = (fine_in   < FLOOR) ? FLOOR : fine_in;
  assign coarse_c = (coarse_in < FLOOR) ? FLOOR : coarse_in;
  assign src      = start ? SRC_FINE : SRC_COARSE;

  always_comb begin
    coarse_d = coarse_q;
    if (start) coarse_d = coarse_c;
    jam_val = (src == SRC_FINE) ? fine_c : coarse_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coarse_q <= FLOOR;
    else        coarse_q <= coarse_d;
  end
endmodule

// File: rtl/extdiv_top.sv
module extdiv_top #(
  parameter int N_W = 16,
  parameter int K_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N_W-1:0] fine_cnt,
  input  logic [N_W-1:0] coarse_cnt,
  input  logic [K_W-1:0] coarse_reps,
  output logic           div_pulse
);
  logic [N_W-1:0] jam_val;
  logic tc, idle, reload, last, start;

  assign start     = idle || (tc && last);
  assign div_pulse = tc && last;

  extdiv_core #(.N_W(N_W)) u_core (
    .clk(clk), .rst_n(rst_n), .jam_val(jam_val),
    .tc(tc), .idle(idle), .reload(reload)
  );

  extdiv_tally #(.K_W(K_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .start(start), .adv(tc),
    .k_in(coarse_reps), .last(last)
  );

  extdiv_jamsel #(.N_W(N_W)) u_jam (
    .clk(clk), .rst_n(rst_n), .start(start),
    .fine_in(fine_cnt), .coarse_in(coarse_cnt), .jam_val(jam_val)
  );

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R6
  reload_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |-> (jam_val >= N_W'(3)));
endmodule

// File: tb/sim_extdiv_top.sv
module sim_extdiv_top;
  localparam int N_W = 16;
  localparam int K_W = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N_W-1:0] fine_cnt, coarse_cnt;
  logic [K_W-1:0] coarse_reps;
  logic           div_pulse;

  always #2.5 clk = ~clk;

  extdiv_top #(.N_W(N_W), .K_W(K_W)) u0 (
    .clk(clk), .rst_n(rst_n), .fine_cnt(fine_cnt), .coarse_cnt(coarse_cnt),
    .coarse_reps(coarse_reps), .div_pulse(div_pulse)
  );

  int     errs = 0, checks = 0;
  longint cyc = 0, last_pulse = 0;
  int     expd = 0;
  string  expd_tag = "R1";
  string  cur_tag = "R1";
  logic   prev_out = 1'b0;

  function automatic int period_of(int f, int c, int k);
    int fc = (f < 3) ? 3 : f;
    int cc = (c < 3) ? 3 : c;
    return fc + k * cc;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint e);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, e);
    end
  endtask

  task automatic step(output bit hit);
    @(negedge clk);
    cyc++;
    hit = 1'b0;
    if (div_pulse) begin
      chk(!prev_out, "R3 pulse width", 2, 1);
      chk((cyc - last_pulse) == expd, expd_tag, cyc - last_pulse, expd);
      last_pulse = cyc;
      expd       = period_of(int'(fine_cnt), int'(coarse_cnt), int'(coarse_reps));
      expd_tag   = cur_tag;
      hit        = 1'b1;
    end
    prev_out = div_pulse;
  endtask

  task automatic wait_pulse();
    bit h;
    do step(h); while (!h);
    step(h);
  endtask

  task automatic set_and_wait(int f, int c, int k, string t);
    fine_cnt    = N_W'(f);
    coarse_cnt  = N_W'(c);
    coarse_reps = K_W'(k);
    cur_tag     = t;
    wait_pulse();
  endtask

  initial begin
    #(190000 * 5);
    errs++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    bit h;
    void'($urandom(32'd4059));
    rst_n       = 1'b0;
    fine_cnt    = 16'd15690;
    coarse_cnt  = 16'd16000;
    coarse_reps = 4'd2;
    repeat (3) @(negedge clk);
    chk(div_pulse == 1'b0, "R1 output low in reset", div_pulse, 0);
    rst_n      = 1'b1;
    cyc        = 0;
    last_pulse = 0;
    expd       = period_of(15690, 16000, 2);
    expd_tag   = "R1 first period";
    step(h);
    chk(div_pulse == 1'b0, "R1 output low after release", div_pulse, 0);
    // R6 clamp of both counts; R5 since set mid-period
    set_and_wait(1, 0, 3, "R6 clamp");
    set_and_wait(40, 7, 0, "R7 K=0");
    set_and_wait(7, 5, 15, "R8 K max");
    set_and_wait(100, 9, 4, "R4 fine then coarse");
    set_and_wait(3, 3, 1, "R6 floor exact");
    for (int i = 0; i < 40; i++) begin
      set_and_wait(3 + int'($urandom % 200), int'($urandom % 120),
                   int'($urandom % 7), "R2 R5 random");
    end
    wait_pulse();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule